// File: doc/BRIEF.md
# Duty Ratio Search Engine

The engine picks an ON/OFF count pair for a clock-suspend modulator. The goal is that the effective frequency, stock × ON / (ON + OFF), lands as close as possible to a requested target. A controller supplies three inputs: the stock frequency, the target frequency and a ceiling on the total period length. It pulses a start line and waits for a one-cycle completion pulse. The chosen counts, the frequency they achieve and a flag telling whether modulation should be switched off are then held on the outputs until the next accepted start.

The search is exhaustive over the candidate total period. It walks every total from the ceiling down to one. For each candidate it runs two divisions, one after the other, on a single shared bit-serial restoring divider. It keeps the best candidate seen so far. Because a tie replaces the held best and the walk runs downward, a tie always favours the shorter period, which gives lower modulation latency. A zero stock frequency cannot be divided by, so it is reported as an error at once.

Top module: `duty_search`

## Requirements
- R1: A period ceiling `max_dur_i` above 255 is treated as 255. A search with ceiling 300 returns exactly what a search with ceiling 255 returns.
- R2: A `start_i` pulse while `busy_o` is low latches target, stock and ceiling, and `busy_o` rises on the next cycle. A `start_i` pulse while `busy_o` is high is ignored, and its inputs do not affect the result. A start in the same cycle as `done_o` is accepted.
- R3: For each candidate total i, ON = floor(target·i/stock) mod 256, OFF = (i − ON) mod 256, and achieved = floor(stock·ON/i) mod 2^32.
- R4: A candidate replaces the held best when |achieved − target| ≤ |best − target|. The walk goes from the ceiling down to 1, so on a tie the smaller total wins.
- R5: Before the walk, the best is stock frequency with ON = 1 and OFF = 0. A ceiling of 0 therefore returns ON = 1, OFF = 0 and freq = stock.
- R6: `done_o` is high for exactly one cycle per search and `busy_o` is low while it is high. `on_o`, `off_o`, `freq_o`, `disable_mod_o` and `err_o` change only in a cycle where `done_o` is high.
- R7: `disable_mod_o` is 1 exactly when the returned frequency equals the latched stock frequency.
- R8: A stock frequency of 0 ends the search within 3 cycles of start. It returns `err_o` = 1, ON = 1, OFF = 0, freq = 0 and `disable_mod_o` = 1.
- R9: After reset, `busy_o`, `done_o`, `err_o`, `disable_mod_o`, `on_o`, `off_o` and `freq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| target_i | input | 32 | Requested frequency, kHz |
| stock_i | input | 32 | Full-speed frequency, kHz |
| max_dur_i | input | 16 | Period ceiling, clamped to 255 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| on_o | output | 8 | Chosen ON count |
| off_o | output | 8 | Chosen OFF count |
| freq_o | output | 32 | Achieved frequency, kHz |
| disable_mod_o | output | 1 | Achieved equals stock; modulation should be off |
| err_o | output | 1 | Stock frequency was zero |

## Verification
Two events can meet on the same clock edge: the completion of one search and the acceptance of the next start. To provoke this, the bench drives `start_i` in the very cycle it sees `done_o` high, with new operands. It then judges two things. First, `busy_o` must rise on the next cycle. Second, the results delivered with that same `done_o` pulse must belong to the first search, and the second search must later produce its own reference values. A start pulsed in the middle of a search, with different operands, must leave the first result untouched.

// File: rtl/duty_pkg.sv
package duty_pkg;
  parameter int unsigned FREQ_W   = 32;
  parameter int unsigned CNT_W    = 8;
  parameter int unsigned DUR_IN_W = 16;
  localparam int unsigned PROD_W    = FREQ_W + CNT_W;
  localparam int unsigned MAX_TOTAL = (1 << CNT_W) - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ON_GO, S_ON_WAIT, S_ACH_GO, S_ACH_WAIT, S_CMP, S_DONE
  } state_e;
endpackage

// File: rtl/duty_div.sv
// Restoring divider, one quotient bit per cycle.
module duty_div #(
  parameter int unsigned DW = 40,
  parameter int unsigned VW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] q_q;
  logic [VW-1:0] rem_q, div_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [VW:0]   rem_sh, diff;
  logic          ge;

  assign rem_sh = {rem_q, q_q[DW-1]};
  assign diff   = rem_sh - {1'b0, div_q};
  assign ge     = rem_sh >= {1'b0, div_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; rem_q <= '0; div_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; done_o <= 1'b0;
    end else if (start_i) begin
      q_q <= dividend_i; rem_q <= '0; div_q <= divisor_i;
      cnt_q <= CW'(DW); run_q <= 1'b1; done_o <= 1'b0;
    end else if (run_q) begin
      rem_q <= ge ? diff[VW-1:0] : rem_sh[VW-1:0];
      q_q   <= {q_q[DW-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q  <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = q_q;
endmodule

// File: rtl/duty_cmp.sv
// Candidate wins when its distance to target is no worse than the best.
module duty_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] best_i,
  input  logic [W-1:0] target_i,
  output logic         take_o
);
  logic [W-1:0] cand_d, best_d;

  always_comb begin
    cand_d = (cand_i >= target_i) ? cand_i - target_i : target_i - cand_i;
    best_d = (best_i >= target_i) ? best_i - target_i : target_i - best_i;
    take_o = cand_d <= best_d;
  end
endmodule

// File: rtl/duty_search.sv
module duty_search
  import duty_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [FREQ_W-1:0]   target_i,
  input  logic [FREQ_W-1:0]   stock_i,
  input  logic [DUR_IN_W-1:0] max_dur_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    on_o,
  output logic [CNT_W-1:0]    off_o,
  output logic [FREQ_W-1:0]   freq_o,
  output logic                disable_mod_o,
  output logic                err_o
);
  state_e              state_q;
  logic [FREQ_W-1:0]   target_q, stock_q, cand_f_q, best_f_q;
  logic [CNT_W-1:0]    idx_q, cand_on_q, cand_off_q, best_on_q, best_off_q;
  logic                err_q;
  logic [CNT_W-1:0]    max_cl;
  logic                div_start, div_done, take;
  logic [PROD_W-1:0]   dividend, quot;
  logic [FREQ_W-1:0]   divisor;

  assign max_cl = (max_dur_i > DUR_IN_W'(MAX_TOTAL)) ? CNT_W'(MAX_TOTAL)
                                                      : max_dur_i[CNT_W-1:0];

  assign div_start = (state_q == S_ON_GO) || (state_q == S_ACH_GO);
  assign dividend  = (state_q == S_ON_GO) ? PROD_W'(target_q) * PROD_W'(idx_q)
                                          : PROD_W'(stock_q) * PROD_W'(cand_on_q);
  assign divisor   = (state_q == S_ON_GO) ? stock_q : FREQ_W'(idx_q);

  duty_div #(.DW(PROD_W), .VW(FREQ_W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .dividend_i(dividend),
    .divisor_i(divisor), .done_o(div_done), .quot_o(quot)
  );

  duty_cmp #(.W(FREQ_W)) u_cmp (
    .cand_i(cand_f_q), .best_i(best_f_q), .target_i(target_q), .take_o(take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      target_q <= '0; stock_q <= '0; cand_f_q <= '0; best_f_q <= '0;
      idx_q <= '0; cand_on_q <= '0; cand_off_q <= '0;
      best_on_q <= '0; best_off_q <= '0; err_q <= 1'b0;
      done_o <= 1'b0; on_o <= '0; off_o <= '0; freq_o <= '0;
      disable_mod_o <= 1'b0; err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          target_q   <= target_i;
          stock_q    <= stock_i;
          idx_q      <= max_cl;
          best_f_q   <= stock_i;
          best_on_q  <= CNT_W'(1);
          best_off_q <= '0;
          err_q      <= (stock_i == '0);
          state_q    <= (stock_i == '0 || max_cl == '0) ? S_DONE : S_ON_GO;
        end
        S_ON_GO:  state_q <= S_ON_WAIT;
        S_ON_WAIT: if (div_done) begin
          cand_on_q  <= quot[CNT_W-1:0];
          cand_off_q <= idx_q - quot[CNT_W-1:0];
          state_q    <= S_ACH_GO;
        end
        S_ACH_GO: state_q <= S_ACH_WAIT;
        S_ACH_WAIT: if (div_done) begin
          cand_f_q <= quot[FREQ_W-1:0];
          state_q  <= S_CMP;
        end
        S_CMP: begin
          if (take) begin
            best_f_q   <= cand_f_q;
            best_on_q  <= cand_on_q;
            best_off_q <= cand_off_q;
          end
          idx_q   <= idx_q - 1'b1;
          state_q <= (idx_q == CNT_W'(1)) ? S_DONE : S_ON_GO;
        end
        S_DONE: begin
          on_o          <= best_on_q;
          off_o         <= best_off_q;
          freq_o        <= best_f_q;
          disable_mod_o <= (best_f_q == stock_q);
          err_o         <= err_q;
          done_o        <= 1'b1;
          state_q       <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/duty_search_chk.sv
module duty_search_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] on_o,
  input logic [7:0] off_o,
  input logic [31:0] freq_o,
  input logic       disable_mod_o,
  input logic       err_o
);
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(on_o) && $stable(off_o) && $stable(freq_o)
                 && $stable(err_o) && $stable(disable_mod_o))); // R6
  AST_ERR_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (on_o == 8'd1 && off_o == 8'd0 && freq_o == 32'd0 && disable_mod_o)); // R8
endmodule

bind duty_search duty_search_chk u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .on_o, .off_o, .freq_o,
  .disable_mod_o, .err_o
);

// File: tb/sim_duty_search.sv
`timescale 1ns/1ps
module sim_duty_search;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] target_i = '0, stock_i = '0;
  logic [15:0] max_dur_i = '0;
  logic        busy_o, done_o, disable_mod_o, err_o;
  logic [7:0]  on_o, off_o;
  logic [31:0] freq_o;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  duty_search u0 (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  typedef struct packed { logic [31:0] tgt; logic [31:0] stk; logic [15:0] md; } vec_t;
  localparam vec_t VECS [8] = '{
    '{32'd150000, 32'd200000, 16'd300},
    '{32'd150000, 32'd200000, 16'd255},
    '{32'd66666,  32'd200000, 16'd255},
    '{32'd1000,   32'd3000,   16'd10},
    '{32'd250000, 32'd233000, 16'd7},
    '{32'd5,      32'd999999, 16'd12},
    '{32'd42,     32'd100,    16'd20},
    '{32'd0,      32'd50000,  16'd9}
  };

  logic [7:0]  m_on, m_off;
  logic [31:0] m_f;

  task automatic model(input logic [31:0] t, input logic [31:0] s, input logic [15:0] md);
    longint bf, c_on, c_f, ci, dt;
    int mx;
    mx = (md > 255) ? 255 : int'(md);
    bf = s; m_on = 8'd1; m_off = 8'd0;
    for (int i = mx; i >= 1; i--) begin
      ci   = i;
      c_on = ((longint'(t) * ci) / longint'(s)) & 255;
      c_f  = ((longint'(s) * c_on) / ci) & 64'hFFFF_FFFF;
      dt   = longint'(t);
      if ((c_f > dt ? c_f - dt : dt - c_f) <= (bf > dt ? bf - dt : dt - bf)) begin
        bf = c_f; m_on = 8'(c_on); m_off = 8'(ci - c_on);
      end
    end
    m_f = 32'(bf);
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] t, input logic [31:0] s, input logic [15:0] md);
    @(negedge clk_i);
    target_i = t; stock_i = s; max_dur_i = md; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic check_result(input string req, input logic [31:0] s);
    check(req, "on", on_o, m_on);
    check(req, "off", off_o, m_off);
    check(req, "freq", freq_o, m_f);
    check(req, "disable_mod", disable_mod_o, (m_f == s));
  endtask

  logic [7:0] on255, off255;
  logic [31:0] f255;

  initial begin
    #25;
    // R9 reset state
    check("R9", "busy", busy_o, 0); check("R9", "done", done_o, 0);
    check("R9", "outs", {on_o, off_o, freq_o, err_o, disable_mod_o}, 0);
    rst_ni = 1'b1;

    // R3 R4 vector table
    for (int k = 0; k < 8; k++) begin
      launch(VECS[k].tgt, VECS[k].stk, VECS[k].md);
      wait_done();
      model(VECS[k].tgt, VECS[k].stk, VECS[k].md);
      check_result("R3", VECS[k].stk);
      check("R8", "err clear", err_o, 0);
      if (k == 0) begin on255 = on_o; off255 = off_o; f255 = freq_o; end
      if (k == 1) begin
        // R1 ceiling 300 equals ceiling 255
        check("R1", "on", on255, on_o); check("R1", "off", off255, off_o);
        check("R1", "freq", f255, freq_o);
      end
    end

    // R4 tie: total 4 and total 2 both give exactly 50 -> shorter wins
    launch(32'd50, 32'd100, 16'd4); wait_done();
    check("R4", "tie on", on_o, 1); check("R4", "tie off", off_o, 1);
    check("R4", "tie freq", freq_o, 50);

    // R5 ceiling 0 keeps initial best
    launch(32'd700, 32'd9000, 16'd0); wait_done();
    check("R5", "on", on_o, 1); check("R5", "off", off_o, 0);
    check("R5", "freq", freq_o, 9000);
    check("R7", "disable at stock", disable_mod_o, 1);

    // R7 target equals stock
    launch(32'd1000, 32'd1000, 16'd5); wait_done();
    check("R7", "on", on_o, 1); check("R7", "off", off_o, 0);
    check("R7", "disable", disable_mod_o, 1);

    // R8 zero stock
    launch(32'd123, 32'd0, 16'd200);
    begin
      int n = 0;
      while (!done_o && n < 5) begin @(negedge clk_i); n++; end
      check("R8", "latency ok", n <= 2, 1);
    end
    check("R8", "err", err_o, 1); check("R8", "on", on_o, 1);
    check("R8", "off", off_o, 0); check("R8", "freq", freq_o, 0);
    check("R8", "disable", disable_mod_o, 1);

    // R6 pulse width and hold
    @(negedge clk_i);
    check("R6", "done one cycle", done_o, 0);
    target_i = 32'd77; stock_i = 32'd88; max_dur_i = 16'd3;
    repeat (4) @(negedge clk_i);
    check("R6", "held err", err_o, 1); check("R6", "held freq", freq_o, 0);

    // R2 mid-run start ignored, then start on the done cycle
    launch(32'd1000, 32'd3000, 16'd6);
    repeat (30) @(negedge clk_i);
    target_i = 32'd2999; stock_i = 32'd3000; max_dur_i = 16'd2; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    wait_done();
    model(32'd1000, 32'd3000, 16'd6);
    check_result("R2", 32'd3000);
    target_i = 32'd2000; stock_i = 32'd3000; max_dur_i = 16'd5; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check("R2", "start on done cycle taken", busy_o, 1);
    check("R6", "first result held", freq_o, m_f);
    wait_done();
    model(32'd2000, 32'd3000, 16'd5);
    check_result("R2", 32'd3000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule